// File: doc/BRIEF.md
# Video Port Write Snooper

This block listens on a host CPU slot bus and copies every I/O write that is aimed at a four-port video processor window into a local replica video core. Each captured write goes into a small in-order queue, tagged with its port index. The block also follows the two-byte address setup protocol of the video processor. Every data-port write therefore becomes a video-memory write request with its own address, sent toward the shared local memory.

In mirroring mode the block is a passive shadow. It never drives the bus data lines and raises no interrupt, so the host's own video chip answers every read and owns the interrupt line. When the relocate input is set, the window moves to a second base. The replica then acts as an extra video processor of its own. It answers reads of its relocated ports from the replica core, and its interrupt request reaches the host.

Top module: `video_port_snooper`

## Requirements
- R1: With `cfg_relocate`=0, an I/O write to an address whose upper six bits match 0x98 (0x98 to 0x9B) is queued toward the replica. The entry holds the port index `io_addr[1:0]` and the byte written. Writes to any other address queue nothing.
- R2: With `cfg_relocate`=1, the window is 0x88 to 0x8B instead. Writes to 0x98 to 0x9B queue nothing and produce no memory request.
- R3: A write is taken when `wr_n` returns high after a cycle in which `iorq_n` and `wr_n` were both low. Its queue entry and any memory request become visible after the first rising clock edge at which `wr_n` is sampled high. Read strobes, and write strobes without `iorq_n`, capture nothing.
- R4: The queue holds up to 4 entries and hands them out in arrival order. `rep_valid` shows that the head entry is present, and the head is removed on a clock edge when `rep_ready`=1.
- R5: A write that arrives while the queue holds 4 entries is dropped, and `ovf` rises and stays high until reset.
- R6: With `cfg_relocate`=0, `bus_oe` is always 0.
- R7: With `cfg_relocate`=1, while `iorq_n`=0, `rd_n`=0 and the address is in the relocated window, `bus_oe`=1 and `bus_dout` equals `rep_rd_data`. `rep_rd_port` carries `io_addr[1:0]`. In every other case `bus_oe`=0.
- R8: `irq_out` follows `rep_irq` when `cfg_relocate`=1 and is 0 when `cfg_relocate`=0.
- R9: Port index 1 takes a two-byte address setup. The first byte becomes address bits 7:0. If bit 7 of the second byte is 0, its bits 5:0 become address bits 13:8 and the new address takes effect. If bit 7 is 1, the pair is a register write and the address stays as it was. A write to port index 0 returns the setup to its first-byte state.
- R10: Each write to port index 0 raises `mem_req_valid` for exactly one cycle, with the current 14-bit address and the data byte. The address then advances by one and wraps from 0x3FFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_relocate | input | 1 | 0 selects the mirroring window, 1 selects the relocated window |
| io_addr | input | 8 | Low byte of the bus address |
| io_din | input | 8 | Bus write data |
| iorq_n | input | 1 | I/O request, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| bus_dout | output | 8 | Read data offered to the bus |
| bus_oe | output | 1 | Enable for driving bus_dout |
| rep_valid | output | 1 | Queue head is present |
| rep_port | output | 2 | Port index of the queue head |
| rep_data | output | 8 | Data byte of the queue head |
| rep_ready | input | 1 | Replica accepts the queue head |
| rep_rd_port | output | 2 | Port index of a bus read, for the replica |
| rep_rd_data | input | 8 | Replica read data |
| rep_irq | input | 1 | Replica interrupt request |
| irq_out | output | 1 | Interrupt toward the host |
| mem_req_valid | output | 1 | One-cycle video memory write request |
| mem_req_addr | output | 14 | Video memory address of the request |
| mem_req_data | output | 8 | Data of the request |
| ovf | output | 1 | Sticky queue overflow flag |

## Verification
The assertions assume that the bus strobes are synchronous to `clk` and that each write strobe stays low for at least one sampled cycle and then returns high for at least one. Two captures therefore never fall on adjacent cycles. They also assume that `cfg_relocate` does not change during a bus cycle. The bench drives every input on the falling edge. It keeps every strobe low for one full cycle and leaves at least one idle cycle between accesses, and it changes the relocate setting only between accesses.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int SNP_IDX_W  = 2;
  localparam int SNP_DATA_W = 8;

  typedef struct packed {
    logic [SNP_IDX_W-1:0]  port;
    logic [SNP_DATA_W-1:0] data;
  } snoop_wr_t;
endpackage

// File: rtl/snoop_capture.sv
module snoop_capture
  import snoop_pkg::*;
#(
  parameter int          IO_AW       = 8,
  parameter logic [7:0]  MIRROR_BASE = 8'h98,
  parameter logic [7:0]  RELOC_BASE  = 8'h88
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_relocate,
  input  logic [IO_AW-1:0]      io_addr,
  input  logic [SNP_DATA_W-1:0] io_din,
  input  logic                  iorq_n,
  input  logic                  wr_n,
  output logic                  win_hit,
  output logic                  ev_valid,
  output snoop_wr_t             ev_entry
);
  localparam int TAG_W = IO_AW - SNP_IDX_W;

  logic [TAG_W-1:0] base_tag;
  logic             active_now;
  logic             act_q, act_d;
  snoop_wr_t        ent_q, ent_d;

  assign base_tag   = cfg_relocate ? RELOC_BASE[IO_AW-1:SNP_IDX_W]
                                   : MIRROR_BASE[IO_AW-1:SNP_IDX_W];
  assign win_hit    = (io_addr[IO_AW-1:SNP_IDX_W] == base_tag);
  assign active_now = !iorq_n && !wr_n && win_hit;

  always_comb begin
    act_d = active_now;
    ent_d = ent_q;
    if (active_now) begin
      ent_d.port = io_addr[SNP_IDX_W-1:0];
      ent_d.data = io_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ent_q <= '0;
    end else begin
      act_q <= act_d;
      ent_q <= ent_d;
    end
  end

  assign ev_valid = act_q && wr_n;
  assign ev_entry = ent_q;
endmodule

// File: rtl/snoop_fifo.sv
module snoop_fifo
  import snoop_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  snoop_wr_t push_entry,
  input  logic      pop,
  output logic      out_valid,
  output snoop_wr_t out_entry,
  output logic      ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  snoop_wr_t        mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             full, do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q | (push && full);
    if (do_push) wp_d = (wp_q == PTR_W'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PTR_W'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[g] <= '0;
      else if (do_push && (wp_q == PTR_W'(g)))
        mem_q[g] <= push_entry;
    end
  end

  assign out_valid = (cnt_q != '0);
  assign out_entry = mem_q[rp_q];
  assign ovf       = ovf_q;
endmodule

// File: rtl/vram_tracker.sv
module vram_tracker
  import snoop_pkg::*;
#(
  parameter int VAW = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_valid,
  input  snoop_wr_t             ev_entry,
  output logic                  req_valid,
  output logic [VAW-1:0]        req_addr,
  output logic [SNP_DATA_W-1:0] req_data
);
  localparam int HI_W = VAW - SNP_DATA_W;

  logic                  phase_q, phase_d;
  logic [SNP_DATA_W-1:0] lo_q, lo_d;
  logic [VAW-1:0]        ptr_q, ptr_d;
  logic                  rv_q, rv_d;
  logic [VAW-1:0]        ra_q, ra_d;
  logic [SNP_DATA_W-1:0] rd_q, rd_d;

  always_comb begin
    phase_d = phase_q;
    lo_d    = lo_q;
    ptr_d   = ptr_q;
    rv_d    = 1'b0;
    ra_d    = ra_q;
    rd_d    = rd_q;
    if (ev_valid) begin
      case (ev_entry.port)
        2'd0: begin
          rv_d    = 1'b1;
          ra_d    = ptr_q;
          rd_d    = ev_entry.data;
          ptr_d   = ptr_q + 1'b1;
          phase_d = 1'b0;
        end
        2'd1: begin
          if (!phase_q) begin
            lo_d    = ev_entry.data;
            phase_d = 1'b1;
          end else begin
            phase_d = 1'b0;
            if (!ev_entry.data[SNP_DATA_W-1])
              ptr_d = {ev_entry.data[HI_W-1:0], lo_q};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      lo_q    <= '0;
      ptr_q   <= '0;
      rv_q    <= 1'b0;
      ra_q    <= '0;
      rd_q    <= '0;
    end else begin
      phase_q <= phase_d;
      lo_q    <= lo_d;
      ptr_q   <= ptr_d;
      rv_q    <= rv_d;
      ra_q    <= ra_d;
      rd_q    <= rd_d;
    end
  end

  assign req_valid = rv_q;
  assign req_addr  = ra_q;
  assign req_data  = rd_q;
endmodule

// File: rtl/video_port_snooper.sv
module video_port_snooper
  import snoop_pkg::*;
#(
  parameter int         IO_AW       = 8,
  parameter int         VAW         = 14,
  parameter int         FIFO_DEPTH  = 4,
  parameter logic [7:0] MIRROR_BASE = 8'h98,
  parameter logic [7:0] RELOC_BASE  = 8'h88
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_relocate,
  input  logic [IO_AW-1:0]      io_addr,
  input  logic [SNP_DATA_W-1:0] io_din,
  input  logic                  iorq_n,
  input  logic                  wr_n,
  input  logic                  rd_n,
  output logic [SNP_DATA_W-1:0] bus_dout,
  output logic                  bus_oe,
  output logic                  rep_valid,
  output logic [SNP_IDX_W-1:0]  rep_port,
  output logic [SNP_DATA_W-1:0] rep_data,
  input  logic                  rep_ready,
  output logic [SNP_IDX_W-1:0]  rep_rd_port,
  input  logic [SNP_DATA_W-1:0] rep_rd_data,
  input  logic                  rep_irq,
  output logic                  irq_out,
  output logic                  mem_req_valid,
  output logic [VAW-1:0]        mem_req_addr,
  output logic [SNP_DATA_W-1:0] mem_req_data,
  output logic                  ovf
);
  logic      win_hit;
  logic      ev_valid;
  snoop_wr_t ev_entry;
  snoop_wr_t head;

  snoop_capture #(
    .IO_AW(IO_AW), .MIRROR_BASE(MIRROR_BASE), .RELOC_BASE(RELOC_BASE)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .cfg_relocate(cfg_relocate),
    .io_addr(io_addr), .io_din(io_din), .iorq_n(iorq_n), .wr_n(wr_n),
    .win_hit(win_hit), .ev_valid(ev_valid), .ev_entry(ev_entry)
  );

  snoop_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(ev_valid), .push_entry(ev_entry),
    .pop(rep_ready), .out_valid(rep_valid), .out_entry(head), .ovf(ovf)
  );

  vram_tracker #(.VAW(VAW)) u_vram (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_entry(ev_entry),
    .req_valid(mem_req_valid), .req_addr(mem_req_addr), .req_data(mem_req_data)
  );

  assign rep_port    = head.port;
  assign rep_data    = head.data;
  assign rep_rd_port = io_addr[SNP_IDX_W-1:0];
  assign bus_oe      = cfg_relocate && win_hit && !iorq_n && !rd_n;
  assign bus_dout    = bus_oe ? rep_rd_data : '0;
  assign irq_out     = cfg_relocate && rep_irq;
endmodule

// File: rtl/snoop_checker.sv
module snoop_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_relocate,
  input logic iorq_n,
  input logic rd_n,
  input logic bus_oe,
  input logic rep_valid,
  input logic rep_ready,
  input logic rep_irq,
  input logic irq_out,
  input logic mem_req_valid,
  input logic ovf
);
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R5
  AST_MIRROR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_relocate |-> !bus_oe); // R6
  AST_READ_ONLY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!rd_n && !iorq_n)); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_relocate || !rep_irq) |-> !irq_out); // R8
  AST_MEM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R10
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !rep_ready) |=> rep_valid); // R4
endmodule

bind video_port_snooper snoop_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_relocate(cfg_relocate), .iorq_n(iorq_n),
  .rd_n(rd_n), .bus_oe(bus_oe), .rep_valid(rep_valid), .rep_ready(rep_ready),
  .rep_irq(rep_irq), .irq_out(irq_out), .mem_req_valid(mem_req_valid), .ovf(ovf)
);

// File: tb/tb_video_port_snooper.sv
module tb_video_port_snooper;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_relocate;
  logic [7:0] io_addr, io_din;
  logic iorq_n, wr_n, rd_n;
  logic [7:0] bus_dout;
  logic bus_oe, rep_valid, rep_ready, rep_irq, irq_out, mem_req_valid, ovf;
  logic [1:0] rep_port, rep_rd_port;
  logic [7:0] rep_data, rep_rd_data, mem_req_data;
  logic [13:0] mem_req_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  video_port_snooper dut (
    .clk(clk), .rst_n(rst_n), .cfg_relocate(cfg_relocate), .io_addr(io_addr),
    .io_din(io_din), .iorq_n(iorq_n), .wr_n(wr_n), .rd_n(rd_n),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .rep_valid(rep_valid),
    .rep_port(rep_port), .rep_data(rep_data), .rep_ready(rep_ready),
    .rep_rd_port(rep_rd_port), .rep_rd_data(rep_rd_data), .rep_irq(rep_irq),
    .irq_out(irq_out), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data), .ovf(ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // write cycle; returns at the falling edge after the capture edge
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input bit use_iorq);
    @(negedge clk);
    io_addr = a; io_din = d; iorq_n = !use_iorq; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; iorq_n = 1'b1;
    @(negedge clk);
  endtask

  // {reloc, addr, data, hit, mem, mem_addr}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 8'h99, 8'h34, 1'b1, 1'b0, 14'h0000},
    {1'b0, 8'h99, 8'h52, 1'b1, 1'b0, 14'h0000},
    {1'b0, 8'h98, 8'hAA, 1'b1, 1'b1, 14'h1234},
    {1'b0, 8'h98, 8'hBB, 1'b1, 1'b1, 14'h1235},
    {1'b0, 8'h88, 8'h11, 1'b0, 1'b0, 14'h0000},
    {1'b0, 8'h9B, 8'h07, 1'b1, 1'b0, 14'h0000},
    {1'b0, 8'h99, 8'h05, 1'b1, 1'b0, 14'h0000},
    {1'b0, 8'h99, 8'h87, 1'b1, 1'b0, 14'h0000},
    {1'b0, 8'h98, 8'hCC, 1'b1, 1'b1, 14'h1236},
    {1'b1, 8'h98, 8'h55, 1'b0, 1'b0, 14'h0000},
    {1'b1, 8'h89, 8'h00, 1'b1, 1'b0, 14'h0000},
    {1'b1, 8'h89, 8'h7F, 1'b1, 1'b0, 14'h0000},
    {1'b1, 8'h88, 8'hEE, 1'b1, 1'b1, 14'h3F00},
    {1'b1, 8'h8A, 8'h01, 1'b1, 1'b0, 14'h0000},
    {1'b1, 8'h89, 8'hFF, 1'b1, 1'b0, 14'h0000},
    {1'b1, 8'h89, 8'h7F, 1'b1, 1'b0, 14'h0000}
  };

  initial begin
    rst_n = 1'b0; cfg_relocate = 1'b0; io_addr = '0; io_din = '0;
    iorq_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; rep_ready = 1'b1;
    rep_rd_data = 8'h5A; rep_irq = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    check(!rep_valid && !mem_req_valid && !ovf && !bus_oe && !irq_out, "R4 reset",
          {rep_valid, mem_req_valid, ovf, bus_oe, irq_out}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R9 R10
    for (int i = 0; i < NV; i++) begin
      cfg_relocate = VEC[i][32];
      bus_write(VEC[i][31:24], VEC[i][23:16], 1'b1);
      check(rep_valid == VEC[i][15], "R1/R2 capture", rep_valid, VEC[i][15]);
      if (VEC[i][15])
        check(rep_port == VEC[i][25:24] && rep_data == VEC[i][23:16], "R1 entry",
              {rep_port, rep_data}, {VEC[i][25:24], VEC[i][23:16]});
      check(mem_req_valid == VEC[i][14], "R10 mem request", mem_req_valid, VEC[i][14]);
      if (VEC[i][14])
        check(mem_req_addr == VEC[i][13:0] && mem_req_data == VEC[i][23:16],
              "R9 mem address", {mem_req_addr, mem_req_data}, {VEC[i][13:0], VEC[i][23:16]});
      @(negedge clk);
    end

    // R10 wrap after setup to 0x3FFF
    bus_write(8'h88, 8'h61, 1'b1);
    check(mem_req_valid && mem_req_addr == 14'h3FFF, "R10 top address", mem_req_addr, 14'h3FFF);
    @(negedge clk);
    bus_write(8'h88, 8'h62, 1'b1);
    check(mem_req_valid && mem_req_addr == 14'h0000, "R10 wrap", mem_req_addr, 0);
    @(negedge clk);

    // R3: read strobe and non-I/O write capture nothing
    cfg_relocate = 1'b0;
    io_addr = 8'h98; iorq_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check(!bus_oe, "R6 mirror read not driven", bus_oe, 0);
    iorq_n = 1'b1; rd_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(!rep_valid && !mem_req_valid, "R3 read ignored", rep_valid, 0);
    bus_write(8'h98, 8'h77, 1'b0);
    check(!rep_valid && !mem_req_valid, "R3 no iorq ignored", rep_valid, 0);

    // R7 relocated read answer
    cfg_relocate = 1'b1;
    io_addr = 8'h8B; iorq_n = 1'b0; rd_n = 1'b0; rep_rd_data = 8'hC3;
    @(negedge clk);
    check(bus_oe && bus_dout == 8'hC3, "R7 read answer", {bus_oe, bus_dout}, {1'b1, 8'hC3});
    check(rep_rd_port == 2'd3, "R7 read port", rep_rd_port, 3);
    io_addr = 8'h98;
    @(negedge clk);
    check(!bus_oe, "R7 outside window", bus_oe, 0);
    iorq_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);

    // R8 interrupt gating
    rep_irq = 1'b1; cfg_relocate = 1'b0;
    @(negedge clk);
    check(!irq_out, "R8 masked in mirror", irq_out, 0);
    cfg_relocate = 1'b1;
    @(negedge clk);
    check(irq_out, "R8 passed when relocated", irq_out, 1);
    rep_irq = 1'b0;

    // R4/R5 fill, overflow, drain order
    rep_ready = 1'b0;
    for (int k = 0; k < 5; k++) begin
      bus_write(8'h8A, 8'hA0 + 8'(k), 1'b1);
      if (k == 3) check(!ovf, "R5 no overflow at four", ovf, 0);
      @(negedge clk);
    end
    check(ovf, "R5 overflow raised", ovf, 1);
    rep_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      check(rep_valid && rep_data == 8'hA0 + 8'(k), "R4 order", rep_data, 8'hA0 + k);
      @(negedge clk);
    end
    check(!rep_valid, "R5 fifth dropped", rep_valid, 0);
    check(ovf, "R5 sticky", ovf, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule